// File: doc/BRIEF.md
# MESI Coherent Line Controller

This block keeps the coherence state of a small, direct-mapped private cache that sits on a shared snooping interconnect. Each line has a tag, one data word and a four-state code: Invalid, Shared, Exclusive or Modified. Local processor reads and writes arrive through a valid/ready handshake. Snoops from other cores arrive on a separate single-cycle port and are answered in the same cycle.

A read that misses asks the interconnect for a fill. The response tells whether another cache also holds the line. A write that does not find the line held exclusively asks for ownership first, and the written word then replaces the whole line. Dirty data leaves the block on a one-cycle write-back port in two cases: when a Modified victim is displaced, and when a snoop reaches a Modified line.

A request is outstanding from the cycle after issue until the response arrives. During that time the processor is stalled, and snoops to other lines are still served normally. The index being refilled is already Invalid during that time. The block needs at least two lines.

Top module: `mesi_line_cache`

## Requirements
- R1: After reset, every line is Invalid. No snoop hits, and every processor access misses until a fill completes.
- R2: A read miss raises `busReqValid` with `busReqRfo`=0 in the cycle after the request. The response installs the line as Exclusive when `busRespShared`=0 and as Shared when `busRespShared`=1. The response data is returned on `cpuRdata`, with `cpuReady`=1, in the response cycle.
- R3: A read that hits a Shared, Exclusive or Modified line completes in the same cycle with `cpuReady`=1 and the stored word. It causes no bus request, no write-back and no state change.
- R4: A write that hits an Exclusive or Modified line completes in the same cycle with no bus request. The line becomes Modified and holds the new word.
- R5: A write to a line that is Shared, Invalid or tagged differently raises `busReqValid` with `busReqRfo`=1. On the response, the line becomes Modified and holds the written word.
- R6: A snoop read (`snpRfo`=0) that hits raises `snpHit`. A Modified line also drives `wbValid` with its address and data in that cycle. A hit line of any valid state ends up Shared.
- R7: A snoop ownership request (`snpRfo`=1) that hits raises `snpHit` and leaves the line Invalid. A Modified line is written back in that cycle first.
- R8: When a miss displaces a Modified line at the same index, the victim's address and data appear on the write-back port in the issue cycle. The index is Invalid until the response.
- R9: While a request is outstanding, `cpuReady` stays 0 and `busReqAddr` stays stable until `busRespValid`. Snoops to other lines are answered as in R6 and R7.
- R10: When a snoop and a processor request arrive with no request outstanding, the snoop is served and the processor request gets `cpuReady`=0. No bus request is issued from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request present; held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Line address: upper bits tag, low bits index |
| cpuWdata | input | DATA_W | Write word |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read word, valid with `cpuReady` on a read |
| busReqValid | output | 1 | Fill or ownership request outstanding |
| busReqRfo | output | 1 | 1 = ownership request, 0 = fill |
| busReqAddr | output | ADDR_W | Requested line address |
| busRespValid | input | 1 | Response to the outstanding request |
| busRespShared | input | 1 | Another cache keeps a copy |
| busRespData | input | DATA_W | Fill data |
| snpValid | input | 1 | Snoop present this cycle |
| snpRfo | input | 1 | 1 = ownership snoop, 0 = read snoop |
| snpAddr | input | ADDR_W | Snooped line address |
| snpHit | output | 1 | This cache holds the snooped line |
| wbValid | output | 1 | Write-back of dirty data this cycle |
| wbAddr | output | ADDR_W | Write-back line address |
| wbData | output | DATA_W | Write-back data |

## Verification
Two functions can fall in the same cycle. One is a snoop to a line. The other is a processor access, either to that same line or to a line being refilled. To provoke the first case, a write to an Exclusive line is presented together with a read snoop of that line. The processor must then stall, and the same write must go on to ask for ownership, because the line has just become Shared. To provoke the second case, snoops to a neighbouring index are sent while a fill is outstanding. They are judged on hit and write-back output against a per-line state model in the bench, and every index is swept through every starting state and every operation.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  // strobes from control into the tag/state/data arrays
  typedef struct packed {
    logic       cpuWrHit;     // silent write into an E/M line
    logic       issue;        // miss issued: drop index to Invalid
    logic       fill;         // response arrives: install line
    lineState_t fillState;
    logic       fillUseWdata; // ownership fill takes the write word
  } lineStrobe_t;

endpackage

// File: rtl/mesi_line_dp.sv
module mesi_line_dp
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              snpValid,
  input  logic              snpRfo,
  input  logic [ADDR_W-1:0] snpAddr,
  output lineState_t        cpuState,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              snpHit,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        stArr  [LINES];
  logic [TAG_W-1:0]  tagArr [LINES];
  logic [DATA_W-1:0] datArr [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx, fillIdx;
  logic [TAG_W-1:0] cpuTag, snpTag, fillTag;
  logic             snpAct, snpDirty, vicDirty;

  assign cpuIdx  = cpuAddr[IDX_W-1:0];
  assign cpuTag  = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx  = snpAddr[IDX_W-1:0];
  assign snpTag  = snpAddr[ADDR_W-1:IDX_W];
  assign fillIdx = fillAddr[IDX_W-1:0];
  assign fillTag = fillAddr[ADDR_W-1:IDX_W];

  assign snpHit   = (stArr[snpIdx] != LINE_I) && (tagArr[snpIdx] == snpTag);
  assign snpAct   = snpValid && snpHit;
  assign snpDirty = snpAct && (stArr[snpIdx] == LINE_M);
  assign vicDirty = stb.issue && (stArr[cpuIdx] == LINE_M);

  assign wbValid = snpDirty || vicDirty;
  assign wbAddr  = snpDirty ? snpAddr : {tagArr[cpuIdx], cpuIdx};
  assign wbData  = snpDirty ? datArr[snpIdx] : datArr[cpuIdx];

  assign cpuState = (tagArr[cpuIdx] == cpuTag) ? stArr[cpuIdx] : LINE_I;
  assign cpuRdata = stb.fill ? busRespData : datArr[cpuIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stArr[i]  <= LINE_I;
        tagArr[i] <= '0;
        datArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snpAct && snpIdx == IDX_W'(i))
          stArr[i] <= snpRfo ? LINE_I : LINE_S;
        if (stb.cpuWrHit && cpuIdx == IDX_W'(i)) begin
          stArr[i]  <= LINE_M;
          datArr[i] <= cpuWdata;
        end
        if (stb.issue && cpuIdx == IDX_W'(i))
          stArr[i] <= LINE_I;
        if (stb.fill && fillIdx == IDX_W'(i)) begin
          stArr[i]  <= stb.fillState;
          tagArr[i] <= fillTag;
          datArr[i] <= stb.fillUseWdata ? cpuWdata : busRespData;
        end
      end
    end
  end

  // R4
  silent_write_to_m_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cpuWrHit |=> stArr[$past(cpuIdx)] == LINE_M);

  // R6
  snoop_read_demote_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpAct && !snpRfo) |=> stArr[$past(snpIdx)] == LINE_S);

  // R7
  snoop_rfo_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpAct && snpRfo) |=> stArr[$past(snpIdx)] == LINE_I);

  // R10
  snoop_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> !(stb.cpuWrHit || stb.issue));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  lineState_t        cpuState,
  input  logic              snpValid,
  input  logic              busRespValid,
  input  logic              busRespShared,
  output lineStrobe_t       stb,
  output logic              cpuReady,
  output logic              busReqValid,
  output logic              busReqRfo,
  output logic [ADDR_W-1:0] busReqAddr
);

  typedef enum logic {CT_IDLE, CT_WAIT} ctrlState_t;

  ctrlState_t        curSt, nxtSt;
  logic [ADDR_W-1:0] pendAddr;
  logic              pendRfo;
  logic              hitOk;

  assign hitOk = (cpuState != LINE_I) &&
                 (!cpuWrite || cpuState == LINE_E || cpuState == LINE_M);

  always_comb begin
    stb      = '0;
    cpuReady = 1'b0;
    nxtSt    = curSt;
    case (curSt)
      CT_IDLE: begin
        if (cpuValid && !snpValid) begin
          if (hitOk) begin
            cpuReady     = 1'b1;
            stb.cpuWrHit = cpuWrite;
          end else begin
            stb.issue = 1'b1;
            nxtSt     = CT_WAIT;
          end
        end
      end
      default: begin
        if (busRespValid) begin
          stb.fill         = 1'b1;
          stb.fillUseWdata = pendRfo;
          stb.fillState    = pendRfo ? LINE_M :
                             (busRespShared ? LINE_S : LINE_E);
          cpuReady         = 1'b1;
          nxtSt            = CT_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSt    <= CT_IDLE;
      pendAddr <= '0;
      pendRfo  <= 1'b0;
    end else begin
      curSt <= nxtSt;
      if (stb.issue) begin
        pendAddr <= cpuAddr;
        pendRfo  <= cpuWrite;
      end
    end
  end

  assign busReqValid = (curSt == CT_WAIT);
  assign busReqRfo   = pendRfo;
  assign busReqAddr  = pendAddr;

  // R9
  stall_while_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busRespValid) |-> !cpuReady);

  // R9
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busRespValid) |=> (busReqValid && $stable(busReqAddr)));

  // R10
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && !busReqValid) |-> !cpuReady);

  // R5
  req_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReqValid) |-> busReqRfo == $past(cpuWrite));

endmodule

// File: rtl/mesi_line_cache.sv
module mesi_line_cache
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic              busReqRfo,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              busRespValid,
  input  logic              busRespShared,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              snpValid,
  input  logic              snpRfo,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpHit,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  lineStrobe_t stb;
  lineState_t  cpuState;

  mesi_line_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuValid     (cpuValid),
    .cpuWrite     (cpuWrite),
    .cpuAddr      (cpuAddr),
    .cpuState     (cpuState),
    .snpValid     (snpValid),
    .busRespValid (busRespValid),
    .busRespShared(busRespShared),
    .stb          (stb),
    .cpuReady     (cpuReady),
    .busReqValid  (busReqValid),
    .busReqRfo    (busReqRfo),
    .busReqAddr   (busReqAddr)
  );

  mesi_line_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .fillAddr   (busReqAddr),
    .busRespData(busRespData),
    .snpValid   (snpValid),
    .snpRfo     (snpRfo),
    .snpAddr    (snpAddr),
    .cpuState   (cpuState),
    .cpuRdata   (cpuRdata),
    .snpHit     (snpHit),
    .wbValid    (wbValid),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );

endmodule

// File: tb/test_mesi_line_cache.sv
module test_mesi_line_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic        cpuReady;
  logic [15:0] cpuRdata;
  logic        busReqValid, busReqRfo;
  logic [7:0]  busReqAddr;
  logic        busRespValid = 1'b0, busRespShared = 1'b0;
  logic [15:0] busRespData = '0;
  logic        snpValid = 1'b0, snpRfo = 1'b0;
  logic [7:0]  snpAddr = '0;
  logic        snpHit, wbValid;
  logic [7:0]  wbAddr;
  logic [15:0] wbData;

  always #2 clk = ~clk;

  mesi_line_cache i_mesi_line_cache (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReqValid(busReqValid), .busReqRfo(busReqRfo), .busReqAddr(busReqAddr),
    .busRespValid(busRespValid), .busRespShared(busRespShared), .busRespData(busRespData),
    .snpValid(snpValid), .snpRfo(snpRfo), .snpAddr(snpAddr),
    .snpHit(snpHit), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
  );

  int checks = 0;
  int errors = 0;

  // bench model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  int          mSt   [4];
  logic [5:0]  mTag  [4];
  logic [15:0] mData [4];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic snoopOnce(input bit rfo, input logic [7:0] a, input string req);
    int idx;
    bit hit, dirty;
    idx   = int'(a[1:0]);
    hit   = (mSt[idx] != 0) && (mTag[idx] == a[7:2]);
    dirty = hit && (mSt[idx] == 3);
    snpValid = 1'b1; snpRfo = rfo; snpAddr = a;
    #1;
    chk(req, "snpHit", 32'(snpHit), 32'(hit));
    chk(req, "wbValid", 32'(wbValid), 32'(dirty));
    if (dirty) begin
      chk(req, "wbAddr", 32'(wbAddr), 32'(a));
      chk(req, "wbData", 32'(wbData), 32'(mData[idx]));
    end
    @(posedge clk);
    if (hit) mSt[idx] = rfo ? 0 : 1;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  task automatic doCpu(input bit wr, input logic [7:0] a, input logic [15:0] wd,
                       input bit shr, input logic [15:0] rd, input bit midSnoop,
                       input string req);
    int idx;
    bit hit, fast, vic;
    idx  = int'(a[1:0]);
    hit  = (mSt[idx] != 0) && (mTag[idx] == a[7:2]);
    fast = hit && (!wr || mSt[idx] >= 2);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    #1;
    if (fast) begin
      chk(req, "cpuReady hit", 32'(cpuReady), 32'd1);
      chk(req, "busReqValid hit", 32'(busReqValid), 32'd0);
      chk(req, "wbValid hit", 32'(wbValid), 32'd0);
      if (!wr) chk(req, "cpuRdata hit", 32'(cpuRdata), 32'(mData[idx]));
      @(posedge clk);
      if (wr) begin mSt[idx] = 3; mData[idx] = wd; end
      @(negedge clk);
      cpuValid = 1'b0;
    end else begin
      vic = (mSt[idx] == 3);
      chk(req, "cpuReady issue", 32'(cpuReady), 32'd0);
      chk(req, "wbValid victim", 32'(wbValid), 32'(vic));
      if (vic) begin
        chk(req, "wbAddr victim", 32'(wbAddr), 32'({mTag[idx], a[1:0]}));
        chk(req, "wbData victim", 32'(wbData), 32'(mData[idx]));
      end
      @(posedge clk);
      mSt[idx] = 0;
      @(negedge clk);
      #1;
      chk(req, "busReqValid", 32'(busReqValid), 32'd1);
      chk(req, "busReqRfo", 32'(busReqRfo), 32'(wr));
      chk(req, "busReqAddr", 32'(busReqAddr), 32'(a));
      chk(req, "cpuReady wait", 32'(cpuReady), 32'd0);
      @(negedge clk);
      if (midSnoop) begin
        snoopOnce(1'b0, a ^ 8'h01, req);
        chk(req, "busReqAddr held", 32'(busReqAddr), 32'(a));
      end
      busRespValid = 1'b1; busRespShared = shr; busRespData = rd;
      #1;
      chk(req, "cpuReady resp", 32'(cpuReady), 32'd1);
      chk(req, "busReqValid resp", 32'(busReqValid), 32'd1);
      if (!wr) chk(req, "cpuRdata resp", 32'(cpuRdata), 32'(rd));
      @(posedge clk);
      mSt[idx]   = wr ? 3 : (shr ? 1 : 2);
      mTag[idx]  = a[7:2];
      mData[idx] = wr ? wd : rd;
      @(negedge clk);
      busRespValid = 1'b0;
      cpuValid = 1'b0;
    end
  endtask

  task automatic prep(input int idx, input int st, input logic [7:0] a);
    snoopOnce(1'b1, {mTag[idx], 2'(idx)}, "R7");
    case (st)
      1: doCpu(1'b0, a, 16'h0, 1'b1, 16'(a) * 16'd3, 1'b0, "R2");
      2: doCpu(1'b0, a, 16'h0, 1'b0, 16'(a) * 16'd5, 1'b0, "R2");
      3: doCpu(1'b1, a, 16'(a) + 16'd7, 1'b0, 16'h0, 1'b0, "R5");
      default: ;
    endcase
  endtask

  task automatic collide(input logic [7:0] a, input logic [15:0] wd);
    int idx;
    idx = int'(a[1:0]);
    cpuValid = 1'b1; cpuWrite = 1'b1; cpuAddr = a; cpuWdata = wd;
    snpValid = 1'b1; snpRfo = 1'b0; snpAddr = a;
    #1;
    chk("R10", "cpuReady on collision", 32'(cpuReady), 32'd0);
    chk("R10", "snpHit on collision", 32'(snpHit), 32'd1);
    chk("R10", "wbValid on collision", 32'(wbValid), 32'd0);
    @(posedge clk);
    mSt[idx] = 1;
    @(negedge clk);
    chk("R10", "no issue on collision", 32'(busReqValid), 32'd0);
    snpValid = 1'b0;
    doCpu(1'b1, a, wd, 1'b0, 16'h0, 1'b0, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "cpuReady idle", 32'(cpuReady), 32'd0);
    chk("R1", "busReqValid idle", 32'(busReqValid), 32'd0);
    chk("R1", "wbValid idle", 32'(wbValid), 32'd0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) snoopOnce(1'b0, 8'(i), "R1");
    doCpu(1'b0, 8'h00, 16'h0, 1'b0, 16'h1234, 1'b0, "R1");

    // sweep: every index x starting state x operation
    for (int idx = 0; idx < 4; idx++) begin
      for (int st = 0; st < 4; st++) begin
        for (int op = 0; op < 6; op++) begin
          logic [5:0]  tg, otg;
          logic [7:0]  a;
          logic [15:0] d;
          tg  = 6'(idx * 5 + st * 3 + op + 1);
          otg = tg ^ 6'h2A;
          a   = {tg, 2'(idx)};
          d   = 16'(idx * 4096 + st * 256 + op * 16 + 3);
          prep(idx, st, a);
          case (op)
            0: doCpu(1'b0, a, d, op[0], d ^ 16'h5A5A, 1'b0, "R3");
            1: doCpu(1'b1, a, d, 1'b0, 16'h0, 1'b0, "R4");
            2: snoopOnce(1'b0, a, "R6");
            3: snoopOnce(1'b1, a, "R7");
            4: doCpu(1'b0, {otg, 2'(idx)}, d, st[0], d + 16'd1, 1'b1, "R8/R9");
            default: doCpu(1'b1, {otg, 2'(idx)}, d, 1'b0, d + 16'd2, 1'b0, "R5");
          endcase
          // follow-up read exposes the resulting state and data
          doCpu(1'b0, a, 16'h0, 1'b1, d ^ 16'h0F0F, 1'b0, "R2");
        end
      end
    end

    // snoop and processor in the same cycle
    for (int idx = 0; idx < 4; idx++) begin
      logic [7:0] a;
      a = {6'(idx + 40), 2'(idx)};
      prep(idx, 2, a);
      collide(a, 16'(16'hC000 + idx));
      snoopOnce(1'b0, a, "R6");
    end

    // reset drops every line to Invalid
    for (int idx = 0; idx < 4; idx++) prep(idx, 3, {6'(idx + 50), 2'(idx)});
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) mSt[i] = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) snoopOnce(1'b1, {6'(i + 50), 2'(i)}, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule